// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a small serial EEPROM that answers as a target on a two-wire bus. It runs on a fast system clock and takes SCL and SDA samples that are already synchronized to that clock. It finds START and STOP conditions from the two samples. It checks the select byte against a fixed type nibble and three strap inputs, and pulls SDA low through an open-drain enable to acknowledge. Its 256-byte array is held in internal registers, which reset to zero.

After a write select, the next byte is taken as the word address. Data bytes that follow go into a two-row staging window, and they are programmed into the array only when a well-placed STOP arrives. A busy timer then runs. It lasts one write time, or twice that when the accepted bytes touch two rows. While the timer runs, no select is acknowledged, so a host can poll until the block is ready. Reads come in three forms: from the current address, from an address set by a dummy write and a repeated START, and as a sequential stream that continues for as long as the host acknowledges.

Top module: `eeprom_target`

## Requirements
- R1: A select byte is acknowledged only when bits 7:4 equal 1010b and bits 3:1 equal `chipSel`. The acknowledge is SDA pulled low for the whole 9th clock. For any other select byte, the block does not drive SDA until the next START.
- R2: Bit 0 of the select byte sets the direction. A 0 means write, and the following byte is the word address. A 1 means read, and the block starts shifting data out as soon as the acknowledge clock ends.
- R3: Each data byte that follows the word address is acknowledged. After the write cycle, a read of its address returns that byte.
- R4: Successive data bytes land at consecutive slots of a 16-byte window. The window is the row of the word address (row = address bits 7:3) followed by the next row, with row 31 followed by row 0. A 17th byte wraps to the first slot of the window and replaces the byte stored there.
- R5: Read data is sent MSB first, and the address increments after every byte, wrapping from 255 to 0. The stream goes on while the host acknowledges. After a host no-acknowledge, SDA is released. A current-address read starts at the address that follows the last byte accessed.
- R6: Programming starts at a STOP only when at least one data byte was accepted and the STOP comes before the second clock of the next byte. A START, or a STOP later in a byte, discards the staged bytes and leaves the array and the timer untouched.
- R7: The SDA pull enable changes only while SCL is low.
- R8: Once programming starts, no select byte is acknowledged for `WRITE_CYCLES` clocks. The period is `2*WRITE_CYCLES` clocks when the accepted bytes lie in two different rows.
- R9: After reset, SDA is released, every array byte reads 0, and the current address is 0.
- R10: A START at any point releases SDA and begins decoding a new select byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronized SCL sample |
| sdaIn | input | 1 | Synchronized SDA sample (wired bus level) |
| chipSel | input | 3 | Strap inputs matched against select bits 3:1 |
| sdaPullEn | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A single STOP can do one of two things. It can end a write phase and start programming, or it can fall inside a byte and abort. Both depend on how many clocks of the next byte were seen when the STOP came. The bench gives STOPs right after a full byte, after three bits, and with no data bytes at all. It judges each by polling at once: an immediate acknowledge means nothing was programmed, and a read-back shows whether the array was touched. The second pair that can coincide is the busy timer running out and a polling select being decoded. Polls are placed at fixed cycle offsets before and after one and two write times, so the one-row and two-row periods can be told apart.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  // Strobes from the bus control to the datapath, at most one action each cycle
  typedef struct packed {
    logic captureBit;  // shift the SDA sample into the byte register
    logic loadAddr;    // take the received byte as word address, open window
    logic stageByte;   // park the received byte in the staging window
    logic clearStage;  // drop every staged byte
    logic commit;      // program staged bytes and start the busy timer
    logic loadShift;   // load the byte at the current address for output
    logic shiftOut;    // advance the output bit
    logic incAddr;     // step the current address after a sent byte
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } busState_e;

endpackage

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int ROW_W        = 3,
  parameter int WRITE_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaIn,
  input  dpStrobe_t  strb,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       busy
);

  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int ROW_BYTES = 1 << ROW_W;
  localparam int SLOTS     = 2 * ROW_BYTES;
  localparam int ROWS_W    = ADDR_W - ROW_W;
  localparam int SLOT_W    = ROW_W + 1;
  localparam int TIMER_W   = $clog2(2 * WRITE_CYCLES + 1);

  logic [7:0]        mem       [MEM_BYTES];
  logic [7:0]        stageData [SLOTS];
  logic [SLOTS-1:0]  stageValid;
  logic [ROWS_W-1:0] winRow;
  logic [ROWS_W-1:0] winNext;
  logic [SLOT_W-1:0] stageOff;
  logic [SLOT_W-1:0] nextOff;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] nextAddr;
  logic [7:0]        shiftReg;
  logic [TIMER_W-1:0] busyCnt;

  logic [MEM_BYTES-1:0] wrEn;
  logic [7:0]           wrData [MEM_BYTES];
  logic                 lowHit, highHit, anyStage;

  assign winNext  = winRow + 1'b1;
  assign nextOff  = stageOff + 1'b1;
  assign nextAddr = {(nextOff[ROW_W] ? winNext : winRow), nextOff[ROW_W-1:0]};
  assign lowHit   = |stageValid[ROW_BYTES-1:0];
  assign highHit  = |stageValid[SLOTS-1:ROW_BYTES];
  assign anyStage = lowHit | highHit;

  assign rxByte = shiftReg;
  assign txBit  = shiftReg[7];
  assign busy   = (busyCnt != '0);

  // Map the two-row staging window onto array positions
  always_comb begin
    for (int j = 0; j < MEM_BYTES; j++) begin
      wrEn[j]   = 1'b0;
      wrData[j] = '0;
      if (ROWS_W'(j >> ROW_W) == winRow) begin
        wrEn[j]   = stageValid[j % ROW_BYTES];
        wrData[j] = stageData[j % ROW_BYTES];
      end else if (ROWS_W'(j >> ROW_W) == winNext) begin
        wrEn[j]   = stageValid[ROW_BYTES + (j % ROW_BYTES)];
        wrData[j] = stageData[ROW_BYTES + (j % ROW_BYTES)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < MEM_BYTES; j++) mem[j] <= '0;
    end else if (strb.commit) begin
      for (int j = 0; j < MEM_BYTES; j++) begin
        if (wrEn[j]) mem[j] <= wrData[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.stageByte) stageData[stageOff] <= shiftReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr       <= '0;
      winRow     <= '0;
      stageOff   <= '0;
      stageValid <= '0;
    end else begin
      if (strb.loadAddr) begin
        addr       <= rxByte[ADDR_W-1:0];
        winRow     <= rxByte[ADDR_W-1:ROW_W];
        stageOff   <= {1'b0, rxByte[ROW_W-1:0]};
        stageValid <= '0;
      end
      if (strb.stageByte) begin
        stageValid[stageOff] <= 1'b1;
        stageOff             <= nextOff;
        addr                 <= nextAddr;
      end
      if (strb.incAddr) addr <= addr + 1'b1;
      if (strb.clearStage || strb.commit) stageValid <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.captureBit) begin
      shiftReg <= {shiftReg[6:0], sdaIn};
    end else if (strb.loadShift) begin
      shiftReg <= mem[addr];
    end else if (strb.shiftOut) begin
      shiftReg <= {shiftReg[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (strb.commit && anyStage) begin
      busyCnt <= (lowHit && highHit) ? TIMER_W'(2 * WRITE_CYCLES)
                                     : TIMER_W'(WRITE_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic       busy,
  output dpStrobe_t  strb,
  output logic       sdaPullEn
);

  logic      sclQ, sdaQ;
  logic      sclRise, sclFall, startCond, stopCond;
  busState_e state, ackTo;
  logic [3:0] bitCnt;
  logic      ackDrive, dataDrive, hostAck;
  logic      rxPhase, byteDone, selMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign sclRise   = sclIn & ~sclQ;
  assign sclFall   = ~sclIn & sclQ;
  assign startCond = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopCond  = sclIn & sclQ & ~sdaQ & sdaIn;

  assign rxPhase  = (state == ST_DEV) || (state == ST_ADDR) || (state == ST_WDATA);
  assign byteDone = sclFall && (bitCnt == 4'd8);
  assign selMatch = (rxByte[7:4] == TYPE_CODE) && (rxByte[3:1] == chipSel) && !busy;

  assign sdaPullEn = ackDrive | (dataDrive & ~txBit);

  always_comb begin
    strb = '0;
    if (startCond) begin
      strb.clearStage = 1'b1;
    end else if (stopCond) begin
      strb.commit = (state == ST_WDATA) && (bitCnt <= 4'd1);
    end else begin
      strb.captureBit = rxPhase && sclRise && (bitCnt < 4'd8);
      strb.loadAddr   = byteDone && (state == ST_ADDR);
      strb.stageByte  = byteDone && (state == ST_WDATA);
      strb.loadShift  = sclFall && (((state == ST_ACK) && (ackTo == ST_RDATA)) ||
                                    ((state == ST_RACK) && hostAck));
      strb.shiftOut   = sclFall && (state == ST_RDATA) && (bitCnt != 4'd0) && (bitCnt < 4'd8);
      strb.incAddr    = sclFall && (state == ST_RDATA) && (bitCnt == 4'd8);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ackTo     <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      dataDrive <= 1'b0;
      hostAck   <= 1'b0;
    end else if (startCond || stopCond) begin
      state     <= startCond ? ST_DEV : ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      dataDrive <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (sclRise && (bitCnt < 4'd8)) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (byteDone) begin
            bitCnt <= '0;
            if ((state != ST_DEV) || selMatch) begin
              ackDrive <= 1'b1;
              state    <= ST_ACK;
              if (state == ST_DEV) ackTo <= rxByte[0] ? ST_RDATA : ST_ADDR;
              else                 ackTo <= ST_WDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            ackDrive  <= 1'b0;
            bitCnt    <= '0;
            state     <= ackTo;
            dataDrive <= (ackTo == ST_RDATA);
          end
        end
        ST_RDATA: begin
          if (sclRise && (bitCnt < 4'd8)) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && (bitCnt == 4'd8)) begin
            dataDrive <= 1'b0;
            bitCnt    <= '0;
            state     <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            hostAck <= ~sdaIn;
          end else if (sclFall) begin
            if (hostAck) begin
              state     <= ST_RDATA;
              dataDrive <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_target.sv
module eeprom_target
  import eeprom_pkg::*;
#(
  parameter int         ADDR_W       = 8,
  parameter int         ROW_W        = 3,
  parameter int         WRITE_CYCLES = 500,
  parameter logic [3:0] TYPE_CODE    = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  output logic       sdaPullEn
);

  dpStrobe_t  strb;
  logic [7:0] rxByte;
  logic       txBit;
  logic       busy;

  eeprom_ctrl #(
    .TYPE_CODE(TYPE_CODE)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .chipSel  (chipSel),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .busy     (busy),
    .strb     (strb),
    .sdaPullEn(sdaPullEn)
  );

  eeprom_datapath #(
    .ADDR_W      (ADDR_W),
    .ROW_W       (ROW_W),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) i_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .sdaIn (sdaIn),
    .strb  (strb),
    .rxByte(rxByte),
    .txBit (txBit),
    .busy  (busy)
  );

endmodule

// File: rtl/eeprom_target_checker.sv
module eeprom_target_checker
  import eeprom_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclIn,
  input logic      sdaIn,
  input logic      sdaPullEn,
  input logic      busy,
  input dpStrobe_t strb
);

  assert_drive_moves_scl_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullEn != $past(sdaPullEn)) |-> !sclIn);

  assert_busy_from_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.commit));

  assert_no_address_while_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAddr |-> !busy);

  assert_commit_on_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (sclIn && sdaIn && !$past(sdaIn)));

  assert_release_on_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && $past(sdaIn) && !sdaIn) |=> !sdaPullEn);

  assert_single_action_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadAddr, strb.stageByte, strb.commit, strb.loadShift,
              strb.shiftOut, strb.incAddr}));

endmodule

bind eeprom_target eeprom_target_checker i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .sclIn    (sclIn),
  .sdaIn    (sdaIn),
  .sdaPullEn(sdaPullEn),
  .busy     (busy),
  .strb     (strb)
);

// File: tb/test_eeprom_target.sv
module test_eeprom_target;

  localparam int W     = 500;
  localparam int Q     = 4;
  localparam int LIMIT = 190000;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaHost = 1'b1;
  logic [2:0] chipSel = CS;
  logic sdaPullEn;
  wire  sdaBus = sdaHost & ~sdaPullEn;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int edgeViol = 0;
  logic [7:0] refMem [256];
  logic prevDrive = 1'b0;

  always #5ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eeprom_target #(.WRITE_CYCLES(W)) i_eeprom_target (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .chipSel(chipSel), .sdaPullEn(sdaPullEn)
  );

  // R7 monitor: the pull enable must not move while SCL is high
  always @(posedge clk) begin
    #2ns;
    if (rstN && (sdaPullEn != prevDrive) && scl) edgeViol = edgeViol + 1;
    prevDrive = sdaPullEn;
  end

  function automatic logic [7:0] devW(input logic [2:0] cs);
    return {4'b1010, cs, 1'b0};
  endfunction
  function automatic logic [7:0] devR(input logic [2:0] cs);
    return {4'b1010, cs, 1'b1};
  endfunction
  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 29 + k * 71 + 5) & 255);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaHost = 1'b1; tq(); scl = 1'b1; tq(); sdaHost = 1'b0; tq(); scl = 1'b0; tq();
  endtask

  task automatic busStop();
    sdaHost = 1'b0; tq(); scl = 1'b1; tq(); sdaHost = 1'b1; tq();
  endtask

  task automatic clkBit(input logic b, output logic s);
    sdaHost = b; tq(); scl = 1'b1; tq(); s = sdaBus; tq(); scl = 1'b0; tq();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(d[i], s);
    clkBit(1'b1, s);
    ack = !s;
  endtask

  task automatic recvByte(input logic hostAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, s);
      d[i] = s;
    end
    clkBit(!hostAck, s);
  endtask

  task automatic pollAck(output logic ack);
    busStart();
    sendByte(devW(CS), ack);
    busStop();
  endtask

  task automatic waitReady();
    logic ack;
    for (int n = 0; n < 30; n++) begin
      pollAck(ack);
      if (ack) break;
    end
  endtask

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Write n bytes from address a; the model follows the two-row window of R4
  task automatic writeSeq(input logic [7:0] a, input int n, input int seed);
    logic ack;
    busStart();
    sendByte(devW(CS), ack);
    check(ack, "R2 write select ack", ack, 1);
    sendByte(a, ack);
    check(ack, "R2 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      int slot, wa;
      logic [7:0] d;
      d = pat(a, k + seed);
      sendByte(d, ack);
      check(ack, "R3 data byte ack", ack, 1);
      slot = (int'(a % 8) + k) % 16;
      wa = (((int'(a >> 3) + slot / 8) % 32) * 8) + slot % 8;
      refMem[wa] = d;
    end
    busStop();
  endtask

  task automatic readCheck(input logic [7:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    busStart();
    sendByte(devW(CS), ack);
    sendByte(a, ack);
    busStart();
    sendByte(devR(CS), ack);
    check(ack, "R2 read select ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, d);
      check(d == refMem[(int'(a) + k) % 256], req, d, refMem[(int'(a) + k) % 256]);
    end
    check(!sdaPullEn, "R5 release after host no-ack", sdaPullEn, 0);
    busStop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) refMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!sdaPullEn, "R9 released after reset", sdaPullEn, 0);

    // R9: current read right after reset starts at address 0 with zero data
    begin
      logic ack;
      logic [7:0] d;
      busStart();
      sendByte(devR(CS), ack);
      check(ack, "R2 read select ack", ack, 1);
      recvByte(1'b1, d);
      check(d == 8'h00, "R9 zero at address 0", d, 0);
      recvByte(1'b0, d);
      check(d == 8'h00, "R9 zero at address 1", d, 0);
      busStop();
    end

    // R1: sweep every select byte against the strap value
    for (int b = 0; b < 256; b++) begin
      logic ack, exp;
      logic [7:0] d;
      exp = (b[7:4] == 4'b1010) && (b[3:1] == CS);
      busStart();
      sendByte(8'(b), ack);
      check(ack == exp, "R1 select decode", ack, exp);
      if (ack && b[0]) recvByte(1'b0, d);
      busStop();
    end

    // R1: sweep strap values against select addresses
    for (int cs = 0; cs < 8; cs++) begin
      chipSel = 3'(cs);
      for (int sel = 0; sel < 8; sel++) begin
        logic ack;
        busStart();
        sendByte(devW(3'(sel)), ack);
        check(ack == (sel == cs), "R1 strap match", ack, sel == cs);
        busStop();
      end
    end
    chipSel = CS;

    // R3: single byte writes
    writeSeq(8'h00, 1, 1); waitReady();
    writeSeq(8'h37, 1, 2); waitReady();
    writeSeq(8'hFF, 1, 3); waitReady();
    readCheck(8'h00, 1, "R3 byte write 00");
    readCheck(8'h37, 1, "R3 byte write 37");
    readCheck(8'hFF, 1, "R3 byte write FF");

    // R8: one-row write keeps the select unacknowledged for W cycles
    begin
      logic ack;
      int t0;
      writeSeq(8'h40, 8, 4);
      t0 = cyc;
      pollAck(ack);
      check(!ack, "R8 busy right after STOP", ack, 0);
      waitUntil(t0 + W - 100 - 140);
      pollAck(ack);
      check(!ack, "R8 busy before one write time", ack, 0);
      waitUntil(t0 + W + 100 - 140);
      pollAck(ack);
      check(ack, "R8 ready after one write time", ack, 1);
      readCheck(8'h40, 8, "R4 one row sequential");
    end

    // R8: write crossing into the next row doubles the busy time
    begin
      logic ack;
      int t0;
      writeSeq(8'h7D, 5, 5);
      t0 = cyc;
      waitUntil(t0 + W + 100 - 140);
      pollAck(ack);
      check(!ack, "R8 two rows still busy", ack, 0);
      waitUntil(t0 + 2 * W + 100 - 140);
      pollAck(ack);
      check(ack, "R8 two rows ready", ack, 1);
      readCheck(8'h7D, 5, "R4 two row write");
    end

    // R4: 17 bytes wrap to the first slot of the window
    writeSeq(8'h90, 17, 6); waitReady();
    readCheck(8'h90, 16, "R4 window wrap");
    // R4: row 31 is followed by row 0
    writeSeq(8'hFC, 10, 7); waitReady();
    readCheck(8'hFC, 4, "R4 row 31 part");
    readCheck(8'h00, 6, "R4 row 0 part");

    // R6: START in the middle of a data byte discards the write
    begin
      logic ack, s;
      busStart();
      sendByte(devW(CS), ack);
      sendByte(8'h20, ack);
      sendByte(8'h11, ack);
      for (int i = 0; i < 3; i++) clkBit(1'b0, s);
      busStart();
      check(!sdaPullEn, "R10 released at START", sdaPullEn, 0);
      sendByte(devW(CS), ack);
      check(ack, "R10 select after restart", ack, 1);
      busStop();
      pollAck(ack);
      check(ack, "R6 START abort starts no busy", ack, 1);
      readCheck(8'h20, 1, "R6 START abort left array");
    end

    // R6: STOP late in a byte discards the write
    begin
      logic ack, s;
      busStart();
      sendByte(devW(CS), ack);
      sendByte(8'h21, ack);
      sendByte(8'h22, ack);
      for (int i = 0; i < 3; i++) clkBit(1'b1, s);
      busStop();
      pollAck(ack);
      check(ack, "R6 STOP mid-byte starts no busy", ack, 1);
      readCheck(8'h21, 1, "R6 STOP mid-byte left array");
    end

    // R6: STOP with no data bytes programs nothing
    begin
      logic ack;
      busStart();
      sendByte(devW(CS), ack);
      sendByte(8'h30, ack);
      busStop();
      pollAck(ack);
      check(ack, "R6 empty write starts no busy", ack, 1);
    end

    // R5: sequential wrap 255 to 0, then current read continues
    readCheck(8'hFE, 4, "R5 sequential wrap");
    begin
      logic ack;
      logic [7:0] d;
      busStart();
      sendByte(devR(CS), ack);
      recvByte(1'b0, d);
      check(d == refMem[8'h02], "R5 current address read", d, refMem[8'h02]);
      check(!sdaPullEn, "R5 release after host no-ack", sdaPullEn, 0);
      busStop();
    end

    // R10: START while a read byte is being shifted out
    begin
      logic ack, s;
      writeSeq(8'h60, 1, 0);
      refMem[8'h60] = pat(8'h60, 0);
      waitReady();
      busStart();
      sendByte(devW(CS), ack);
      sendByte(8'h60, ack);
      busStart();
      sendByte(devR(CS), ack);
      clkBit(1'b1, s);
      check(s == refMem[8'h60][7], "R5 MSB first", s, refMem[8'h60][7]);
      busStart();
      check(!sdaPullEn, "R10 release at START in read", sdaPullEn, 0);
      sendByte(devW(CS), ack);
      check(ack, "R10 select decoded after START", ack, 1);
      busStop();
    end

    check(edgeViol == 0, "R7 drive changes with SCL low", edgeViol, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", LIMIT, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule